// File: doc/BRIEF.md
# Serial Peripheral Transceiver with Status Flags

This block is a full-duplex, four-wire serial peripheral transceiver. It exchanges 8-bit characters with a partner device. A CPU reaches it through three byte-wide registers: control, status and data. Bit 1 of the control register makes it either the clock source (master), which drives the serial clock from a programmable divider, or a clocked follower (slave), which takes the serial clock and an active-low select from outside. In slave mode those pins pass through a two-flop synchronizer, and their edges are detected in the system clock domain.

Transmit data goes directly into the shift register. A write to the data register while a transfer is active is discarded and raises a collision flag. Receive is double-buffered: each completed character is copied into a read buffer, so the next character can arrive while the CPU fetches the previous one. A character that completes while the buffer is still unread raises an overrun flag and leaves the buffer as it was. The serial clock idles low. Data is sampled on its rising edge and changed on its falling edge. The interrupt output follows the completion flag, gated by an enable bit.

Register map: address 0 is control (bit 0 enable, bit 1 master, bit 2 interrupt enable). Address 1 is status (bit 0 complete, bit 1 collision, bit 2 overrun). Address 2 is data: a write loads the shift register, and a read returns the read buffer.

Top module: `spi_xcvr`

## Requirements
- R1: Each character has eight bits. It is shifted out most significant bit first, and a character is shifted in at the same time.
- R2: With control bit 1 set, the block drives `sck_o`, and a data write while idle starts a transfer. With it clear, `sck_o` stays low and the block is clocked by `sck_i`, whose levels must each last at least two system clocks.
- R3: In master mode the serial clock has a period of 2*DIV_HALF system clocks (at most half the system clock rate). It idles low, and data changes only on its falling edge.
- R4: In slave mode the block takes part only while `ss_n_i` is low. While `ss_n_i` is high, edges on `sck_i` and `mosi_i` have no effect, and `miso_oe` is 0.
- R5: When the eighth bit is received, the character is copied into the read buffer. A data-register read returns it.
- R6: If a character completes while the read buffer holds an unread character, status bit 2 (overrun) is set and the buffer keeps the older character.
- R7: A data write during an active transfer is discarded. The transfer continues unchanged, and status bit 1 (collision) is set. In slave mode, a transfer is active while the block is selected.
- R8: Status bit 0 (complete) is set when the last bit of a character has been shifted.
- R9: `irq` is high exactly while status bit 0 is set and control bit 2 is 1.
- R10: A status read while a flag is set, followed by any data-register access, clears that flag. `irq` drops with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | Output enable for miso_o |
| miso_i | input | 1 | Serial data in for master mode |

## Verification
A wrong bit counter or shift path shows up at the data register one character later: a rotated or truncated byte, or a completion flag that rises one SCK period early or late. A wrong divider shows as a measurable SCK period on the very first bit. Flag bookkeeping errors show up only at the next status read, as a stuck or missing complete, collision or overrun bit, and at `irq` in the same cycle. A select synchronizer fault shows within two system clocks, as `miso_oe` asserting while `ss_n_i` is high or a character counted without selection.

// File: rtl/spi_xcvr.sv
module spi_xcvr #(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sck_o,
  input  logic       sck_i,
  input  logic       ss_n_i,
  output logic       mosi_o,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_HALF - 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic          en, mst, ie;
  logic          busy, sck_q, samp;
  logic [7:0]    shreg, rbuf;
  logic [2:0]    bcnt;
  logic [CW-1:0] div;
  logic [2:0]    sck_s;
  logic [1:0]    ss_s;
  logic          rfull;
  logic          done, wcol, ovr;
  logic          arm_done, arm_wcol, arm_ovr;

  wire wr_ctl  = wr_en && addr == A_CTRL;
  wire wr_dat  = wr_en && addr == A_DATA;
  wire rd_sta  = rd_en && addr == A_STAT;
  wire rd_dat  = rd_en && addr == A_DATA;
  wire dat_acc = wr_dat || rd_dat;

  wire sel    = en && !mst && !ss_s[1];
  wire tick   = busy && div == DIV_LAST;
  wire m_rise = tick && !sck_q;
  wire m_fall = tick && sck_q;
  wire s_rise = sel && sck_s[1] && !sck_s[2];
  wire s_fall = sel && !sck_s[1] && sck_s[2];
  wire fall   = m_fall || s_fall;
  wire cmpl   = fall && bcnt == 3'd7;
  wire xfer   = mst ? busy : sel;
  wire coll   = wr_dat && xfer;
  wire [7:0] rx_char = {shreg[6:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 3'b000;
      ss_s  <= 2'b11;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ss_s  <= {ss_s[0], ss_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mst <= 1'b0; ie <= 1'b0;
    end else if (wr_ctl) begin
      {ie, mst, en} <= wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sck_q <= 1'b0;
      div   <= '0;
      bcnt  <= 3'd0;
      samp  <= 1'b0;
      shreg <= 8'h00;
    end else begin
      if (busy) div <= tick ? '0 : div + CW'(1);
      if (wr_dat && !xfer) begin
        shreg <= wdata;
        if (en && mst) begin
          busy  <= 1'b1;
          div   <= '0;
          bcnt  <= 3'd0;
          sck_q <= 1'b0;
        end
      end
      if (m_rise) begin
        sck_q <= 1'b1;
        samp  <= miso_i;
      end
      if (s_rise) samp <= mosi_i;
      if (fall) begin
        shreg <= rx_char;
        bcnt  <= bcnt + 3'd1;
        if (m_fall) sck_q <= 1'b0;
        if (cmpl && mst) busy <= 1'b0;
      end
      if (!mst && !sel) bcnt <= 3'd0;
      if (wr_ctl && !(wdata[0] && wdata[1])) begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= 8'h00; rfull <= 1'b0;
      done <= 1'b0; wcol <= 1'b0; ovr <= 1'b0;
      arm_done <= 1'b0; arm_wcol <= 1'b0; arm_ovr <= 1'b0;
    end else begin
      if (rd_dat) rfull <= 1'b0;
      if (rd_sta) begin
        arm_done <= arm_done | done;
        arm_wcol <= arm_wcol | wcol;
        arm_ovr  <= arm_ovr  | ovr;
      end
      if (dat_acc) begin
        if (arm_done) done <= 1'b0;
        if (arm_wcol) wcol <= 1'b0;
        if (arm_ovr)  ovr  <= 1'b0;
        arm_done <= 1'b0; arm_wcol <= 1'b0; arm_ovr <= 1'b0;
      end
      if (coll) wcol <= 1'b1;
      if (cmpl) begin
        done <= 1'b1;
        if (rfull && !rd_dat) ovr <= 1'b1;
        else begin
          rbuf  <= rx_char;
          rfull <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {5'b0, ie, mst, en};
      A_STAT:  rdata = {5'b0, ovr, wcol, done};
      A_DATA:  rdata = rbuf;
      default: rdata = 8'h00;
    endcase
  end

  assign irq     = done && ie;
  assign sck_o   = sck_q;
  assign mosi_o  = mst && shreg[7];
  assign miso_o  = shreg[7];
  assign miso_oe = sel;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ss_n_i,
  input logic       miso_oe,
  input logic       sck_o,
  input logic       irq,
  input logic       mst,
  input logic       xfer,
  input logic       wr_dat,
  input logic       dat_acc,
  input logic       wr_ctl,
  input logic       rd_dat,
  input logic       cmpl,
  input logic       rfull,
  input logic [7:0] rbuf,
  input logic       done,
  input logic       wcol,
  input logic       ovr
);
  AST_SLAVE_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    !mst |-> !sck_o);                                          // R2
  AST_MISO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !$past(ss_n_i, 2));                            // R4
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl && rfull && !rd_dat |=> $stable(rbuf) && ovr);        // R6
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat && xfer |=> wcol);                                  // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> done);                                            // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(dat_acc) || $past(wr_ctl));           // R10
endmodule

bind spi_xcvr spi_xcvr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ss_n_i(ss_n_i), .miso_oe(miso_oe),
  .sck_o(sck_o), .irq(irq), .mst(mst), .xfer(xfer), .wr_dat(wr_dat),
  .dat_acc(dat_acc), .wr_ctl(wr_ctl), .rd_dat(rd_dat), .cmpl(cmpl),
  .rfull(rfull), .rbuf(rbuf), .done(done), .wcol(wcol), .ovr(ovr)
);

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF = 2;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'hFF00, 16'h6996};

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, sck_o, mosi_o, miso_o, miso_oe;
  logic sck_i = 0, ss_n_i = 1, mosi_i = 0, miso_i = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  spi_xcvr #(.DIV_HALF(DIV_HALF)) i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_o(sck_o), .sck_i(sck_i),
    .ss_n_i(ss_n_i), .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .miso_i(miso_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rx, input int coll_at,
                        output logic [7:0] mo);
    logic [7:0] got = 0;
    miso_i = rx[7];
    write_reg(2'd2, tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o);
      got[7-i] = mosi_o;
      if (i == coll_at) write_reg(2'd2, 8'h5A);
      @(negedge sck_o);
      if (i < 7) miso_i = rx[6-i];
    end
    @(negedge clk);
    mo = got;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic s_xfer(input logic [7:0] mb, output logic [7:0] so, output logic oe_seen);
    logic [7:0] got = 0;
    oe_seen = 1;
    @(negedge clk); ss_n_i = 0;
    wait_clk(4);
    for (int i = 0; i < 8; i++) begin
      mosi_i = mb[7-i];
      wait_clk(4);
      got[7-i] = miso_o;
      oe_seen = oe_seen & miso_oe;
      sck_i = 1;
      wait_clk(4);
      sck_i = 0;
    end
    wait_clk(4);
    ss_n_i = 1;
    wait_clk(4);
    so = got;
  endtask

  task automatic clear_flags(output logic [7:0] d);
    logic [7:0] s;
    read_reg(2'd1, s);
    read_reg(2'd2, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, mo, so;
    logic oe;
    int cnt;
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);
    read_reg(2'd0, d); check("R2 reset ctrl", d, 8'h00);
    read_reg(2'd1, d); check("R8 reset status", d, 8'h00);
    check("R9 reset irq", irq, 0);
    check("R2 reset sck", sck_o, 0);
    check("R4 reset miso_oe", miso_oe, 0);

    write_reg(2'd0, 8'h07);
    for (int k = 0; k < NVEC; k++) begin
      m_xfer(VEC[k][15:8], VEC[k][7:0], -1, mo);
      check("R1 master mosi order", mo, VEC[k][15:8]);
      read_reg(2'd1, d); check("R8 complete flag", d, 8'h01);
      check("R9 irq with enable", irq, 1);
      read_reg(2'd2, d); check("R5 received char", d, VEC[k][7:0]);
      check("R10 irq cleared", irq, 0);
      read_reg(2'd1, d); check("R10 status cleared", d, 8'h00);
    end

    miso_i = 0;
    write_reg(2'd2, 8'h33);
    @(posedge sck_o);
    cnt = 0;
    @(negedge clk);
    while (!sck_o || cnt == 0) begin cnt++; @(negedge clk); if (!sck_o) cnt = cnt; end
    while (sck_o) begin cnt++; @(negedge clk); end
    while (!sck_o) begin cnt++; @(negedge clk); end
    check("R3 sck period", cnt, 2*DIV_HALF);
    wait_clk(40);
    clear_flags(d);

    m_xfer(8'hC6, 8'h3A, 3, mo);
    check("R7 transfer undisturbed", mo, 8'hC6);
    read_reg(2'd1, d); check("R7 collision flag", d, 8'h03);
    read_reg(2'd2, d); check("R7 received intact", d, 8'h3A);
    read_reg(2'd1, d); check("R10 collision cleared", d, 8'h00);

    m_xfer(8'h11, 8'h4B, -1, mo);
    m_xfer(8'h22, 8'hE7, -1, mo);
    read_reg(2'd1, d); check("R6 overrun flag", d, 8'h05);
    read_reg(2'd2, d); check("R6 buffer kept", d, 8'h4B);
    read_reg(2'd1, d); check("R10 overrun cleared", d, 8'h00);

    write_reg(2'd0, 8'h03);
    m_xfer(8'h5E, 8'h81, -1, mo);
    check("R9 irq masked", irq, 0);
    read_reg(2'd1, d); check("R8 complete masked irq", d, 8'h01);
    read_reg(2'd2, d); check("R5 char masked irq", d, 8'h81);

    write_reg(2'd0, 8'h05);
    write_reg(2'd2, 8'hC3);
    check("R4 miso_oe unselected", miso_oe, 0);
    mosi_i = 1;
    for (int i = 0; i < 8; i++) begin
      wait_clk(4); sck_i = 1; wait_clk(4); sck_i = 0;
    end
    wait_clk(4);
    check("R2 slave sck_o quiet", sck_o, 0);
    read_reg(2'd1, d); check("R4 ignored while deselected", d, 8'h00);
    check("R4 miso_oe still off", miso_oe, 0);

    s_xfer(8'h96, so, oe);
    check("R1 slave miso order", so, 8'hC3);
    check("R4 miso_oe while selected", oe, 1);
    check("R9 irq slave", irq, 1);
    read_reg(2'd1, d); check("R8 slave complete", d, 8'h01);
    read_reg(2'd2, d); check("R5 slave received", d, 8'h96);

    @(negedge clk); ss_n_i = 0;
    wait_clk(4);
    write_reg(2'd2, 8'h11);
    check("R7 slave shreg kept", miso_o, 1'b1);
    @(negedge clk); ss_n_i = 1;
    wait_clk(4);
    read_reg(2'd1, d); check("R7 slave collision", d, 8'h02);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule